// File: doc/BRIEF.md
# Manchester Line Collision and End-of-Frame Detector

This block sits behind the input synchronizer of a serial receiver whose line carries Manchester-coded data, sampled eight times per bit. The strobe `smp_en` marks each clock cycle that holds a new line sample. Only strobed cycles advance the detector. Each bit cell holds the inverse of the bit in its first half and the bit in its second half, so a mid-cell edge into high is a 1 and a mid-cell edge into low is a 0.

The detector measures how many samples each line level lasts and checks that length against windows that depend on the kind of edge that started the run. An edge can be at a cell boundary or at a cell centre. The outcome is one of three reports:
- a decoded bit, reported at each mid-cell edge;
- a collision pulse, when the waveform cannot come from a single legal transmitter;
- a sticky line-idle flag, when the line stays high for an end-of-frame.

After a collision or an end-of-frame, the detector drops into a hunt state. It waits there for the next falling edge, which it takes as the centre of a 0 cell.

In the requirements, "k samples after sample X" means this: the output pulse appears in the clock cycle that follows the strobe of the k-th sample after X, where X is the first sample at the new level. With eight samples per bit, half a bit is 4 samples.

Top module: `manch_coll_det`

## Requirements
- R1: After reset, `bit_vld`, `bit_val`, `coll` and `line_idle` are all 0, and the detector is hunting.
- R2: A legal stream is decoded without any collision. Legal runs are 3 to 5 samples for a half-bit run and 6 to 10 samples for a centre-to-centre run. Each mid-cell edge gives one `bit_vld` pulse, and `bit_val` is the new level (1 = high second half).
- R3: A level that lasts only 1 or 2 samples between two edges is a collision. `coll` pulses 3 samples after the second edge.
- R4: After a falling edge at a cell boundary, a low run of up to 5 samples is legal. A 6th low sample is a collision, and `coll` pulses 8 samples after that falling edge.
- R5: After a falling edge at a cell centre, a low run of up to 10 samples is legal. An 11th low sample is a collision, and `coll` pulses 13 samples after that falling edge.
- R6: A high run longer than its legal limit (5 after a boundary rise, 10 after a centre rise) marks a possible end-of-frame. If the line is still high one bit after the expected midpoint, `line_idle` is set. That is sample 12 after a boundary rise or sample 16 after a centre rise. The detector then hunts.
- R7: A falling edge that arrives during that end-of-frame window is a collision, and `coll` pulses 4 samples after that falling edge.
- R8: After a collision or an end-of-frame, no bit or collision is reported until the next falling edge. That edge gives a `bit_vld` pulse with `bit_val` 0.
- R9: `line_idle` stays set until `idle_clr` is high in a cycle. If an end-of-frame is confirmed in the same cycle as a clear, the flag ends up set.
- R10: Cycles with `smp_en` low change no state, and the line is ignored in them. Output pulses last one cycle and only follow a strobed cycle.
- R11: A strobe with `rx_en` low sends the detector to hunt. This cancels any pending collision, and no bit or collision is reported while reception is disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_en | input | 1 | High in cycles that carry a new line sample |
| line_smp | input | 1 | Synchronized line sample |
| rx_en | input | 1 | Reception enable; low forces the hunt state |
| idle_clr | input | 1 | Clears the line-idle flag |
| bit_vld | output | 1 | One-cycle pulse per decoded bit |
| bit_val | output | 1 | Value of the latest decoded bit |
| coll | output | 1 | One-cycle collision pulse |
| line_idle | output | 1 | Sticky end-of-frame flag |

## Verification
The assertions watch, on every cycle, the properties that hold for any stimulus:
- pulses and flag changes follow only strobed cycles;
- bit and collision reports never coincide;
- the idle flag holds until cleared;
- a disabled receiver stays silent;
- the first bit after a hunt is 0.

Only the bench scenarios can show the exact sample on which each collision lands for each kind of run violation, the end-of-frame sample for both kinds of rising edge, the decoded bit order under jitter, and the cancelling of a pending collision by `rx_en`.

// File: rtl/mcd_pkg.sv
// Shared types for the Manchester collision detector.
package mcd_pkg;

    // Detector operating state.
    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,   // waiting for a falling edge to lock on
        ST_TRACK = 2'd1,   // timing runs between edges
        ST_PEND  = 2'd2    // collision seen, waiting to report it
    } mcd_state_e;

    // Position of the edge that opened the current run.
    typedef enum logic {
        EDGE_BOUND = 1'b0,  // at a cell boundary
        EDGE_MID   = 1'b1   // at a cell centre
    } edge_kind_e;

    // Per-sample events from the FSM to the output stage.
    typedef struct packed {
        logic bit_fire;
        logic bit_lvl;
        logic coll_fire;
        logic eof_fire;
    } mcd_evt_t;

endpackage

// File: rtl/mcd_run_track.sv
// Run-length tracker.
// Keeps the previous line sample and counts the samples spent at the
// current level. On a strobe it reports whether the sample toggled the
// line, whether that toggle was a falling edge, the length of the run
// that just ended and the length of the run including this sample.
// Assumes: line_smp is already synchronized; counting saturates.
module mcd_run_track #(
    parameter int RUN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_en,
    input  logic             line_smp,
    output logic             tog,
    output logic             fall,
    output logic [RUN_W-1:0] prev_run,
    output logic [RUN_W-1:0] cur_run
);

    localparam logic [RUN_W-1:0] RUN_MAX = '1;
    localparam logic [RUN_W-1:0] RUN_ONE = RUN_W'(1);

    logic             prv_q;
    logic [RUN_W-1:0] run_q;

    // Edge detection against the previous strobed sample.
    always_comb begin
        tog  = smp_en && (line_smp != prv_q);
        fall = tog && !line_smp;
    end

    // Run length including the present sample, saturating.
    always_comb begin
        prev_run = run_q;
        if (tog)
            cur_run = RUN_ONE;
        else if (run_q == RUN_MAX)
            cur_run = run_q;
        else
            cur_run = run_q + RUN_ONE;
    end

    // Store the sample and run length on every strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prv_q <= 1'b0;
            run_q <= '0;
        end else if (smp_en) begin
            prv_q <= line_smp;
            run_q <= cur_run;
        end
    end

endmodule

// File: rtl/mcd_fsm.sv
// Timing-window state machine.
// Classifies every edge as cell-boundary or cell-centre from the run
// that preceded it. It flags runs that are too short, low runs that are
// too long and high runs that miss their midpoint. Collisions are
// reported after a fixed delay in samples. A high run that stays long
// enough confirms an end-of-frame.
// Assumes: SPB is a multiple of 8; all inputs valid only with smp_en.
module mcd_fsm
    import mcd_pkg::*;
#(
    parameter int SPB   = 8,
    parameter int RUN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_en,
    input  logic             rx_en,
    input  logic             line_smp,
    input  logic             tog,
    input  logic             fall,
    input  logic [RUN_W-1:0] prev_run,
    input  logic [RUN_W-1:0] cur_run,
    output mcd_evt_t         evt
);

    localparam int HALF      = SPB / 2;
    localparam int EIGHTH    = SPB / 8;
    localparam int NARROW    = HALF - 2 * EIGHTH;      // longest illegal run
    localparam int LIM_B     = HALF + EIGHTH;          // after boundary edge
    localparam int LIM_M     = SPB + 2 * EIGHTH;       // after centre edge
    localparam int CONF_B    = HALF + SPB + 1;         // idle confirm, boundary
    localparam int CONF_M    = 2 * SPB + 1;            // idle confirm, centre
    localparam int DLY_LOW   = 3 * EIGHTH;             // report delay, short/low
    localparam int DLY_UNEXP = HALF;                   // report delay, late fall
    localparam int DLY_MAX   = (DLY_LOW > DLY_UNEXP) ? DLY_LOW : DLY_UNEXP;
    localparam int DLY_W     = $clog2(DLY_MAX + 1);

    localparam logic [RUN_W-1:0] NARROW_V = RUN_W'(NARROW);
    localparam logic [RUN_W-1:0] LIM_B_V  = RUN_W'(LIM_B);
    localparam logic [RUN_W-1:0] LIM_M_V  = RUN_W'(LIM_M);
    localparam logic [RUN_W-1:0] OVR_B_V  = RUN_W'(LIM_B + 1);
    localparam logic [RUN_W-1:0] OVR_M_V  = RUN_W'(LIM_M + 1);
    localparam logic [RUN_W-1:0] CONF_B_V = RUN_W'(CONF_B);
    localparam logic [RUN_W-1:0] CONF_M_V = RUN_W'(CONF_M);
    localparam logic [DLY_W-1:0] DLY_LOW_V   = DLY_W'(DLY_LOW);
    localparam logic [DLY_W-1:0] DLY_UNEXP_V = DLY_W'(DLY_UNEXP);
    localparam logic [DLY_W-1:0] DLY_ONE_V   = DLY_W'(1);

    mcd_state_e       st_q, st_nxt;
    edge_kind_e       kind_q, kind_nxt;
    logic [DLY_W-1:0] dly_q, dly_nxt;
    logic [RUN_W-1:0] lim, ovr, conf;

    // Windows that apply to the run opened by the last edge.
    always_comb begin
        if (kind_q == EDGE_MID) begin
            lim  = LIM_M_V;
            ovr  = OVR_M_V;
            conf = CONF_M_V;
        end else begin
            lim  = LIM_B_V;
            ovr  = OVR_B_V;
            conf = CONF_B_V;
        end
    end

    // Next-state and event decode for one strobed sample.
    always_comb begin
        st_nxt   = st_q;
        kind_nxt = kind_q;
        dly_nxt  = dly_q;
        evt      = '0;
        if (smp_en) begin
            if (!rx_en) begin
                st_nxt = ST_HUNT;
            end else begin
                unique case (st_q)
                    ST_HUNT: begin
                        if (fall) begin
                            st_nxt       = ST_TRACK;
                            kind_nxt     = EDGE_MID;
                            evt.bit_fire = 1'b1;
                            evt.bit_lvl  = 1'b0;
                        end
                    end
                    ST_TRACK: begin
                        if (tog) begin
                            if (prev_run <= NARROW_V) begin
                                st_nxt  = ST_PEND;
                                dly_nxt = DLY_LOW_V;
                            end else if (!line_smp && prev_run > lim) begin
                                st_nxt  = ST_PEND;
                                dly_nxt = DLY_UNEXP_V;
                            end else if (prev_run <= LIM_B_V && kind_q == EDGE_MID) begin
                                kind_nxt = EDGE_BOUND;
                            end else begin
                                kind_nxt     = EDGE_MID;
                                evt.bit_fire = 1'b1;
                                evt.bit_lvl  = line_smp;
                            end
                        end else if (!line_smp && cur_run == ovr) begin
                            st_nxt  = ST_PEND;
                            dly_nxt = DLY_LOW_V;
                        end else if (line_smp && cur_run == conf) begin
                            st_nxt       = ST_HUNT;
                            evt.eof_fire = 1'b1;
                        end
                    end
                    ST_PEND: begin
                        if (dly_q == DLY_ONE_V) begin
                            st_nxt        = ST_HUNT;
                            evt.coll_fire = 1'b1;
                        end else begin
                            dly_nxt = dly_q - DLY_ONE_V;
                        end
                    end
                    default: st_nxt = ST_HUNT;
                endcase
            end
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_HUNT;
            kind_q <= EDGE_MID;
            dly_q  <= '0;
        end else begin
            st_q   <= st_nxt;
            kind_q <= kind_nxt;
            dly_q  <= dly_nxt;
        end
    end

endmodule

// File: rtl/mcd_report.sv
// Output stage.
// Registers the per-sample events into one-cycle pulses, holds the last
// decoded bit value and keeps the sticky line-idle flag.
// Assumes: events are already qualified by the sample strobe.
module mcd_report
    import mcd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  mcd_evt_t evt,
    input  logic     idle_clr,
    output logic     bit_vld,
    output logic     bit_val,
    output logic     coll,
    output logic     line_idle
);

    // Pulse, value and sticky-flag registers; a set beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_vld   <= 1'b0;
            bit_val   <= 1'b0;
            coll      <= 1'b0;
            line_idle <= 1'b0;
        end else begin
            bit_vld   <= evt.bit_fire;
            coll      <= evt.coll_fire;
            if (evt.bit_fire)
                bit_val <= evt.bit_lvl;
            line_idle <= evt.eof_fire || (line_idle && !idle_clr);
        end
    end

endmodule

// File: rtl/manch_coll_det.sv
// Manchester line collision and end-of-frame detector, top level.
// It chains the run tracker, the timing FSM and the output stage.
// Assumes: the line is oversampled SPB times per bit, and SPB is a
// multiple of 8.
module manch_coll_det
    import mcd_pkg::*;
#(
    parameter int SPB = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_en,
    input  logic line_smp,
    input  logic rx_en,
    input  logic idle_clr,
    output logic bit_vld,
    output logic bit_val,
    output logic coll,
    output logic line_idle
);

    localparam int RUN_W = $clog2(2 * SPB + 2);

    logic             tog, fall;
    logic [RUN_W-1:0] prev_run, cur_run;
    mcd_evt_t         evt;
    logic             eof_pulse;

    // End-of-frame event, exposed for the bound checker.
    assign eof_pulse = evt.eof_fire;

    mcd_run_track #(.RUN_W(RUN_W)) u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_en   (smp_en),
        .line_smp (line_smp),
        .tog      (tog),
        .fall     (fall),
        .prev_run (prev_run),
        .cur_run  (cur_run)
    );

    mcd_fsm #(.SPB(SPB), .RUN_W(RUN_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_en   (smp_en),
        .rx_en    (rx_en),
        .line_smp (line_smp),
        .tog      (tog),
        .fall     (fall),
        .prev_run (prev_run),
        .cur_run  (cur_run),
        .evt      (evt)
    );

    mcd_report u_rep (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt),
        .idle_clr  (idle_clr),
        .bit_vld   (bit_vld),
        .bit_val   (bit_val),
        .coll      (coll),
        .line_idle (line_idle)
    );

endmodule

// File: rtl/mcd_chk.sv
// Protocol checker for manch_coll_det, attached with bind.
// Tracks whether the detector must be hunting, from its own outputs
// and the end-of-frame event.
module mcd_chk (
    input logic clk,
    input logic rst_n,
    input logic smp_en,
    input logic rx_en,
    input logic idle_clr,
    input logic bit_vld,
    input logic bit_val,
    input logic coll,
    input logic line_idle,
    input logic eof_pulse
);

    logic hunting;

    // Hunting after reset, collision, end-of-frame or a disabled strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hunting <= 1'b1;
        else if (coll || eof_pulse || (smp_en && !rx_en))
            hunting <= 1'b1;
        else if (bit_vld)
            hunting <= 1'b0;
    end

    a_r10_pulse_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld || coll) |-> $past(smp_en));

    a_r10_idle_rise_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_idle) |-> $past(smp_en));

    a_r2_bit_coll_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_vld && coll));

    a_r9_idle_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (line_idle && !idle_clr) |=> line_idle);

    a_r6_eof_sets_idle: assert property (@(posedge clk) disable iff (!rst_n)
        eof_pulse |=> line_idle);

    a_r11_silent_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_en && !rx_en) |=> (!bit_vld && !coll));

    a_r8_first_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (hunting && bit_vld) |-> !bit_val);

endmodule

bind manch_coll_det mcd_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_en    (smp_en),
    .rx_en     (rx_en),
    .idle_clr  (idle_clr),
    .bit_vld   (bit_vld),
    .bit_val   (bit_val),
    .coll      (coll),
    .line_idle (line_idle),
    .eof_pulse (eof_pulse)
);

// File: tb/manch_coll_det_tb_top.sv
// Self-checking bench: a behavioural per-sample model compared each clock,
// plus scenario checks on the sample index of every reported event.
module manch_coll_det_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_en = 1'b0;
    logic line_smp = 1'b1;
    logic rx_en = 1'b1;
    logic idle_clr = 1'b0;
    logic bit_vld, bit_val, coll, line_idle;

    always #2 clk = ~clk;

    manch_coll_det #(.SPB(8)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_en    (smp_en),
        .line_smp  (line_smp),
        .rx_en     (rx_en),
        .idle_clr  (idle_clr),
        .bit_vld   (bit_vld),
        .bit_val   (bit_val),
        .coll      (coll),
        .line_idle (line_idle)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int gap = 0;

    // Reference model state: sample count, edge positions, mode.
    int    n = 0;
    int    md = 0;            // 0 hunt, 1 track, 2 pending report
    int    prev_lvl = 0;
    int    edge_at = 0;
    int    fire_at = 0;
    bit    mid_k = 1'b1;
    string coll_tag = "R2";
    bit    exp_bv = 0, exp_bval = 0, exp_coll = 0, exp_idle = 0;

    // Observations.
    int coll_cnt = 0, bit_cnt = 0, last_coll_smp = -1, idle_rise_smp = -1;
    int bits_sr = 0;
    bit idle_seen = 0;

    task automatic chk(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Behavioural model of one clock cycle.
    function automatic void model_step(bit s, bit lvl, bit rx, bit clr);
        bit eof = 0;
        int r, lim, conf;
        exp_bv = 0;
        exp_coll = 0;
        if (s) begin
            n++;
            lim  = mid_k ? 10 : 5;
            conf = mid_k ? 17 : 13;
            if (!rx) begin
                md = 0;
            end else if (md == 0) begin
                if (prev_lvl == 1 && lvl == 0) begin
                    md = 1; mid_k = 1; exp_bv = 1; exp_bval = 0;
                end
            end else if (md == 1) begin
                if (lvl != prev_lvl) begin
                    r = n - edge_at;
                    if (r <= 2) begin
                        md = 2; fire_at = n + 3; coll_tag = "R3";
                    end else if (lvl == 0 && r > lim) begin
                        md = 2; fire_at = n + 4; coll_tag = "R7";
                    end else if (r <= 5 && mid_k) begin
                        mid_k = 0;
                    end else begin
                        mid_k = 1; exp_bv = 1; exp_bval = lvl;
                    end
                end else begin
                    r = n - edge_at + 1;
                    if (lvl == 0 && r == lim + 1) begin
                        md = 2; fire_at = n + 3; coll_tag = mid_k ? "R5" : "R4";
                    end else if (lvl == 1 && r == conf) begin
                        md = 0; eof = 1;
                    end
                end
            end else begin
                if (n == fire_at) begin
                    md = 0; exp_coll = 1;
                end
            end
            if (lvl != prev_lvl) edge_at = n;
            prev_lvl = lvl;
        end
        exp_idle = eof ? 1'b1 : (clr ? 1'b0 : exp_idle);
    endfunction

    // One clock: drive at negedge, compare after the next posedge.
    task automatic tick(bit s, bit lvl, bit clr);
        smp_en = s;
        line_smp = lvl;
        idle_clr = clr;
        model_step(s, lvl, rx_en, clr);
        @(posedge clk);
        @(negedge clk);
        chk("R2", "bit_vld", int'(bit_vld), int'(exp_bv));
        if (exp_bv) chk("R2", "bit_val", int'(bit_val), int'(exp_bval));
        chk(exp_coll ? coll_tag : "R2", "coll", int'(coll), int'(exp_coll));
        chk("R6", "line_idle", int'(line_idle), int'(exp_idle));
        if (coll) begin coll_cnt++; last_coll_smp = n; end
        if (bit_vld) begin bit_cnt++; bits_sr = (bits_sr << 1) | int'(bit_val); end
        if (line_idle && !idle_seen) idle_rise_smp = n;
        idle_seen = line_idle;
        smp_en = 1'b0;
        idle_clr = 1'b0;
    endtask

    // Send cnt samples at one level, with gap cycles of the opposite level.
    task automatic put(bit lvl, int cnt);
        for (int i = 0; i < cnt; i++) begin
            tick(1'b1, lvl, 1'b0);
            for (int k = 0; k < gap; k++) tick(1'b0, !lvl, 1'b0);
        end
    endtask

    // Force the hunt state with the line high.
    task automatic rehunt();
        rx_en = 1'b0;
        put(1'b1, 3);
        rx_en = 1'b1;
        put(1'b1, 3);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000) begin
            n_bad++;
            $display("FAIL R1 watchdog: actual %0d expected below 200000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int m, c0, b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "bit_vld", int'(bit_vld), 0);
        chk("R1", "bit_val", int'(bit_val), 0);
        chk("R1", "coll", int'(coll), 0);
        chk("R1", "line_idle", int'(line_idle), 0);

        // R2 and R6: jittered legal stream, then boundary-rise end-of-frame
        gap = 1;
        rehunt();
        c0 = coll_cnt; b0 = bit_cnt;
        put(0, 4);
        put(0, 4); put(1, 4);
        put(0, 3); put(1, 5);
        put(1, 4); put(0, 4);
        put(1, 4); put(0, 3);
        put(0, 4); put(1, 4);
        put(1, 5); put(0, 4);
        m = n + 1;
        put(1, 16);
        chk("R2", "bit count", bit_cnt - b0, 7);
        chk("R2", "bit pattern", bits_sr & 8'h7f, 7'b0110010);
        chk("R2", "collisions in legal stream", coll_cnt - c0, 0);
        chk("R6", "idle sample after boundary rise", idle_rise_smp - m, 12);

        // R9: clear of the sticky flag
        tick(1'b0, 1'b1, 1'b1);
        chk("R9", "line_idle after clear", int'(line_idle), 0);

        // R3 and R8: short high pulse, then silence until the next fall
        rehunt();
        c0 = coll_cnt;
        put(0, 4); put(1, 2);
        m = n + 1;
        put(0, 6);
        chk("R3", "short-high collision offset", last_coll_smp - m, 3);
        chk("R3", "short-high collision count", coll_cnt - c0, 1);
        b0 = bit_cnt;
        put(1, 4);
        chk("R8", "bits while hunting", bit_cnt - b0, 0);
        put(0, 4);
        chk("R8", "bits after relock", bit_cnt - b0, 1);
        chk("R8", "relock bit value", bits_sr & 1, 0);

        // R3: one-sample low pulse
        rehunt();
        put(0, 4); put(1, 4); put(0, 1);
        m = n + 1;
        put(1, 6);
        chk("R3", "short-low collision offset", last_coll_smp - m, 3);

        // R4: low overrun after a boundary fall, and its legal limit
        rehunt();
        put(0, 8); put(1, 4);
        m = n + 1;
        put(0, 12);
        chk("R4", "boundary low overrun offset", last_coll_smp - m, 8);
        rehunt();
        c0 = coll_cnt;
        put(0, 8); put(1, 4); put(0, 5); put(1, 4);
        chk("R4", "five low samples accepted", coll_cnt - c0, 0);

        // R5: low overrun after a centre fall, and its legal limit
        rehunt();
        m = n + 1;
        put(0, 14);
        chk("R5", "centre low overrun offset", last_coll_smp - m, 13);
        rehunt();
        c0 = coll_cnt; b0 = bit_cnt;
        put(0, 10); put(1, 4);
        chk("R5", "ten low samples accepted", coll_cnt - c0, 0);
        chk("R5", "bits across long low", bit_cnt - b0, 2);

        // R7: fall inside the end-of-frame window
        rehunt();
        put(0, 8); put(1, 12);
        m = n + 1;
        put(0, 8);
        chk("R7", "late fall collision offset", last_coll_smp - m, 4);

        // R6 and R9: centre-rise end-of-frame confirmed together with a clear
        tick(1'b0, 1'b1, 1'b1);
        rehunt();
        put(0, 8);
        m = n + 1;
        put(1, 16);
        tick(1'b1, 1'b1, 1'b1);
        chk("R6", "idle sample after centre rise", idle_rise_smp - m, 16);
        chk("R9", "set beats clear", int'(line_idle), 1);

        // R11: disabling reception cancels a pending collision
        rehunt();
        c0 = coll_cnt;
        put(0, 4); put(1, 2); put(0, 1);
        b0 = bit_cnt;
        rx_en = 1'b0;
        put(0, 5); put(1, 3); put(0, 3); put(1, 3);
        chk("R11", "collisions while disabled", coll_cnt - c0, 0);
        chk("R11", "bits while disabled", bit_cnt - b0, 0);
        rx_en = 1'b1;

        // R10: wide strobe gaps, then a long stall with a toggling line
        gap = 3;
        rehunt();
        b0 = bit_cnt;
        put(0, 8); put(1, 4); put(0, 4); put(1, 2);
        chk("R10", "bits with wide gaps", bit_cnt - b0, 3);
        chk("R10", "bit pattern with wide gaps", bits_sr & 3'h7, 3'b011);
        b0 = bit_cnt; c0 = coll_cnt;
        for (int i = 0; i < 24; i++) tick(1'b0, i[0], 1'b0);
        chk("R10", "bits during stall", bit_cnt - b0, 0);
        chk("R10", "collisions during stall", coll_cnt - c0, 0);
        gap = 0;
        put(1, 4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule